// File: doc/BRIEF.md
# GCM Counter-Mode Block Sequencer

This block drives the counter half of a Galois/counter mode datapath. After a 96-bit initial vector is loaded it forms the initial counter block and sends it to an external 128-bit block cipher through a valid/ready request port. The cipher's answer to that first block is kept on a dedicated output so the tag logic can use it later. Every data block offered on the input port then gets the next counter block: the lowest 32 bits go up by one and the upper 96 bits stay the same. The cipher's reply for that counter block is XORed onto the data. The same path serves both directions, because encrypting and decrypting are the same operation here.

A final block shorter than 16 bytes carries a byte count. The block treats the missing bytes as zero. It returns only the counted bytes and forces every byte beyond them to zero. Bytes are numbered from the most significant end: byte 0 occupies bits 127:120.

The controller has six states. ST_IDLE waits for the first IV. ST_REQ_Y0 offers the initial counter block to the cipher. ST_WAIT_Y0 waits for the reply and stores it. ST_READY accepts an IV reload, which has priority, or a data block. ST_REQ_DATA offers the data's counter block. ST_WAIT_DATA waits for the reply and produces the output.

The transitions are:
- ST_IDLE to ST_REQ_Y0 on IV load.
- ST_REQ_Y0 to ST_WAIT_Y0 on request accept.
- ST_WAIT_Y0 to ST_READY on response.
- ST_READY to ST_REQ_Y0 on IV load.
- ST_READY to ST_REQ_DATA on data accept.
- ST_REQ_DATA to ST_WAIT_DATA on request accept.
- ST_WAIT_DATA to ST_READY on response.

Top module: `gcm_ctr_engine`

## Requirements
- R1: An IV is accepted only when `iv_ready` is high, which is in ST_IDLE and ST_READY. An IV presented in any other state is ignored. The first cipher request after an accepted IV carries the IV in bits 127:32, zeros in bits 31:1 and a one in bit 0.
- R2: Every later cipher request carries the previous request's block with bits 31:0 increased by one and bits 127:32 unchanged.
- R3: The 32-bit increment field wraps from all ones to zero without changing the upper bits. The field width is the parameter INC_W.
- R4: For each accepted data block, `dout_valid` pulses for one cycle, on the clock edge after the cipher response is taken. At that pulse `dout_block` is the data block XOR that response.
- R5: A byte count n from 1 to 16 keeps output bytes 0 to n-1 and forces the rest to zero. Byte 0 is bits 127:120. A count of 0 or above 16 is treated as 16. `dout_nbytes` reports the count after this adjustment.
- R6: The response to the initial counter block appears on `ek0_block` with `ek0_valid` high. It stays unchanged until the next accepted IV, which clears `ek0_valid` on the edge that accepts it.
- R7: Once raised, a cipher request stays valid with a stable block until `ciph_req_ready` is seen. Only one request is in flight at a time. `din_ready` is high only in ST_READY and only while no IV is offered.
- R8: After reset, `iv_ready` is high and every other valid and ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iv_valid | input | 1 | IV offered |
| iv_ready | output | 1 | IV can be taken this cycle |
| iv_data | input | 96 | Initial vector |
| din_valid | input | 1 | Data block offered |
| din_ready | output | 1 | Data block can be taken this cycle |
| din_block | input | 128 | Plaintext or ciphertext block |
| din_nbytes | input | 5 | Valid byte count of the block |
| ciph_req_valid | output | 1 | Counter block offered to the cipher |
| ciph_req_ready | input | 1 | Cipher takes the counter block |
| ciph_req_block | output | 128 | Counter block |
| ciph_rsp_valid | input | 1 | Cipher result present |
| ciph_rsp_block | input | 128 | Encrypted counter block |
| dout_valid | output | 1 | Result pulse |
| dout_block | output | 128 | Masked XOR result |
| dout_nbytes | output | 5 | Adjusted byte count of the result |
| ek0_valid | output | 1 | Encrypted initial block is held |
| ek0_block | output | 128 | Encrypted initial counter block |

## Verification
The hardest case to reach is the wrap of the increment field, because a 96-bit IV always starts that field at one. At the default width, reaching the wrap would take about four billion blocks. The bench therefore adds a second instance with INC_W set to 3 and streams blocks through it continuously. That forces the field through zero within nine requests, and the bench checks that the upper bits survive the wrap. On the main instance, the bench varies cipher stalls and response delays. It also pulses an IV while a request is outstanding, to show that the IV is ignored in those states.

// File: rtl/gcm_ctr_pkg.sv
`timescale 1ns/1ps
package gcm_ctr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_Y0,
        ST_WAIT_Y0,
        ST_READY,
        ST_REQ_DATA,
        ST_WAIT_DATA
    } eng_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/gcm_ctr_counter.sv
`timescale 1ns/1ps
module gcm_ctr_counter #(
    parameter int BLK_W = 128,
    parameter int INC_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [BLK_W-INC_W-1:0]   iv_i,
    input  logic                     step_i,
    output logic [BLK_W-1:0]         ctr_o
);

    localparam int IV_W = BLK_W - INC_W;

    logic [BLK_W-1:0] ctr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else if (load_i) begin
            ctr_q <= {iv_i, {(INC_W-1){1'b0}}, 1'b1};
        end else if (step_i) begin
            ctr_q[INC_W-1:0] <= ctr_q[INC_W-1:0] + 1'b1;
        end
    end

    assign ctr_o = ctr_q;

    assert_upper_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> ctr_o[BLK_W-1:INC_W] == $past(ctr_o[BLK_W-1:INC_W]));

    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && (&ctr_o[INC_W-1:0])) |=> ctr_o[INC_W-1:0] == '0);

    assert_iv_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ctr_o[BLK_W-1:INC_W] == $past(iv_i));

    initial begin
        assert (IV_W > 0) else $error("increment field leaves no IV bits");
    end

endmodule

// File: rtl/gcm_ctr_xormask.sv
`timescale 1ns/1ps
module gcm_ctr_xormask #(
    parameter int BLK_W = 128,
    parameter int NB_W  = 5
) (
    input  logic [BLK_W-1:0] data_i,
    input  logic [BLK_W-1:0] ks_i,
    input  logic [NB_W-1:0]  nbytes_i,
    output logic [BLK_W-1:0] blk_o
);

    import gcm_ctr_pkg::*;

    localparam int NBYTES = BLK_W / BYTE_W;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam int HI = BLK_W - 1 - BYTE_W * i;
        assign blk_o[HI -: BYTE_W] = (NB_W'(i) < nbytes_i)
                                   ? (data_i[HI -: BYTE_W] ^ ks_i[HI -: BYTE_W])
                                   : '0;
    end

endmodule

// File: rtl/gcm_ctr_engine.sv
`timescale 1ns/1ps
module gcm_ctr_engine #(
    parameter int BLK_W = 128,
    parameter int INC_W = 32,
    localparam int IV_W   = BLK_W - INC_W,
    localparam int NBYTES = BLK_W / 8,
    localparam int NB_W   = $clog2(NBYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iv_valid,
    output logic              iv_ready,
    input  logic [IV_W-1:0]   iv_data,
    input  logic              din_valid,
    output logic              din_ready,
    input  logic [BLK_W-1:0]  din_block,
    input  logic [NB_W-1:0]   din_nbytes,
    output logic              ciph_req_valid,
    input  logic              ciph_req_ready,
    output logic [BLK_W-1:0]  ciph_req_block,
    input  logic              ciph_rsp_valid,
    input  logic [BLK_W-1:0]  ciph_rsp_block,
    output logic              dout_valid,
    output logic [BLK_W-1:0]  dout_block,
    output logic [NB_W-1:0]   dout_nbytes,
    output logic              ek0_valid,
    output logic [BLK_W-1:0]  ek0_block
);

    import gcm_ctr_pkg::*;

    eng_state_t state_q, state_d;

    logic             ctr_load, ctr_step;
    logic             din_take, ek_capture, out_capture;
    logic [NB_W-1:0]  nb_norm;
    logic [BLK_W-1:0] din_q;
    logic [NB_W-1:0]  nb_q;
    logic [BLK_W-1:0] mask_out;

    // byte count adjustment: 0 or oversize means a full block
    always_comb begin
        if (din_nbytes == '0 || din_nbytes > NB_W'(NBYTES)) begin
            nb_norm = NB_W'(NBYTES);
        end else begin
            nb_norm = din_nbytes;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (iv_valid) state_d = ST_REQ_Y0;
            ST_REQ_Y0:    if (ciph_req_ready) state_d = ST_WAIT_Y0;
            ST_WAIT_Y0:   if (ciph_rsp_valid) state_d = ST_READY;
            ST_READY: begin
                if (iv_valid)       state_d = ST_REQ_Y0;
                else if (din_valid) state_d = ST_REQ_DATA;
            end
            ST_REQ_DATA:  if (ciph_req_ready) state_d = ST_WAIT_DATA;
            ST_WAIT_DATA: if (ciph_rsp_valid) state_d = ST_READY;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        iv_ready       = 1'b0;
        din_ready      = 1'b0;
        ciph_req_valid = 1'b0;
        ctr_load       = 1'b0;
        ctr_step       = 1'b0;
        din_take       = 1'b0;
        ek_capture     = 1'b0;
        out_capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                iv_ready = 1'b1;
                ctr_load = iv_valid;
            end
            ST_REQ_Y0: begin
                ciph_req_valid = 1'b1;
            end
            ST_WAIT_Y0: begin
                ek_capture = ciph_rsp_valid;
                ctr_step   = ciph_rsp_valid;
            end
            ST_READY: begin
                iv_ready  = 1'b1;
                din_ready = !iv_valid;
                ctr_load  = iv_valid;
                din_take  = !iv_valid && din_valid;
            end
            ST_REQ_DATA: begin
                ciph_req_valid = 1'b1;
            end
            ST_WAIT_DATA: begin
                out_capture = ciph_rsp_valid;
                ctr_step    = ciph_rsp_valid;
            end
            default: begin
                iv_ready = 1'b0;
            end
        endcase
    end

    gcm_ctr_counter #(
        .BLK_W (BLK_W),
        .INC_W (INC_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ctr_load),
        .iv_i   (iv_data),
        .step_i (ctr_step),
        .ctr_o  (ciph_req_block)
    );

    gcm_ctr_xormask #(
        .BLK_W (BLK_W),
        .NB_W  (NB_W)
    ) u_xormask (
        .data_i   (din_q),
        .ks_i     (ciph_rsp_block),
        .nbytes_i (nb_q),
        .blk_o    (mask_out)
    );

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q       <= '0;
            nb_q        <= '0;
            dout_valid  <= 1'b0;
            dout_block  <= '0;
            dout_nbytes <= '0;
            ek0_valid   <= 1'b0;
            ek0_block   <= '0;
        end else begin
            dout_valid <= 1'b0;
            if (din_take) begin
                din_q <= din_block;
                nb_q  <= nb_norm;
            end
            if (ctr_load) begin
                ek0_valid <= 1'b0;
            end else if (ek_capture) begin
                ek0_valid <= 1'b1;
                ek0_block <= ciph_rsp_block;
            end
            if (out_capture) begin
                dout_valid  <= 1'b1;
                dout_block  <= mask_out;
                dout_nbytes <= nb_q;
            end
        end
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ciph_req_valid && !ciph_req_ready) |=> (ciph_req_valid && $stable(ciph_req_block)));

    assert_single_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> !ciph_req_valid);

    assert_first_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_valid && iv_ready) |=> (ciph_req_valid && ciph_req_block[INC_W-1:0] == INC_W'(1)));

    assert_ek0_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ek0_valid && !(iv_valid && iv_ready)) |=> (ek0_valid && $stable(ek0_block)));

    assert_dout_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (dout_nbytes != '0 && dout_nbytes <= NB_W'(NBYTES)));

    assert_dout_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

endmodule

// File: tb/gcm_ctr_engine_bench.sv
`timescale 1ns/1ps
module gcm_ctr_engine_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;

    // main instance signals
    logic         iv_valid = 1'b0;
    logic         iv_ready;
    logic [95:0]  iv_data = '0;
    logic         din_valid = 1'b0;
    logic         din_ready;
    logic [127:0] din_block = '0;
    logic [4:0]   din_nbytes = '0;
    logic         ciph_req_valid;
    logic         ciph_req_ready = 1'b1;
    logic [127:0] ciph_req_block;
    logic         ciph_rsp_valid = 1'b0;
    logic [127:0] ciph_rsp_block = '0;
    logic         dout_valid;
    logic [127:0] dout_block;
    logic [4:0]   dout_nbytes;
    logic         ek0_valid;
    logic [127:0] ek0_block;

    gcm_ctr_engine u_gcm_ctr_engine (
        .clk(clk), .rst_n(rst_n),
        .iv_valid(iv_valid), .iv_ready(iv_ready), .iv_data(iv_data),
        .din_valid(din_valid), .din_ready(din_ready), .din_block(din_block), .din_nbytes(din_nbytes),
        .ciph_req_valid(ciph_req_valid), .ciph_req_ready(ciph_req_ready), .ciph_req_block(ciph_req_block),
        .ciph_rsp_valid(ciph_rsp_valid), .ciph_rsp_block(ciph_rsp_block),
        .dout_valid(dout_valid), .dout_block(dout_block), .dout_nbytes(dout_nbytes),
        .ek0_valid(ek0_valid), .ek0_block(ek0_block)
    );

    // narrow instance for the wrap case (R3)
    logic         n_iv_valid = 1'b0;
    logic         n_iv_ready;
    logic [124:0] n_iv_data = 125'h0ABC_DEF0_1234_5678_9ABC_DEF0_1234_5678;
    logic         n_din_valid = 1'b0;
    logic         n_din_ready;
    logic         n_req_valid;
    logic [127:0] n_req_block;
    logic         n_rsp_valid = 1'b0;
    logic         n_dout_valid;
    logic [127:0] n_dout_block;
    logic [4:0]   n_dout_nbytes;
    logic         n_ek0_valid;
    logic [127:0] n_ek0_block;

    gcm_ctr_engine #(.BLK_W(128), .INC_W(3)) u_gcm_ctr_engine_narrow (
        .clk(clk), .rst_n(rst_n),
        .iv_valid(n_iv_valid), .iv_ready(n_iv_ready), .iv_data(n_iv_data),
        .din_valid(n_din_valid), .din_ready(n_din_ready), .din_block(128'h5), .din_nbytes(5'd16),
        .ciph_req_valid(n_req_valid), .ciph_req_ready(1'b1), .ciph_req_block(n_req_block),
        .ciph_rsp_valid(n_rsp_valid), .ciph_rsp_block(128'h0),
        .dout_valid(n_dout_valid), .dout_block(n_dout_block), .dout_nbytes(n_dout_nbytes),
        .ek0_valid(n_ek0_valid), .ek0_block(n_ek0_block)
    );

    function automatic logic [127:0] ks_of(input logic [127:0] b);
        return {b[100:0], b[127:101]} ^ 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    endfunction

    function automatic int norm_nb(input logic [4:0] n);
        return (n == 0 || n > 16) ? 16 : int'(n);
    endfunction

    function automatic logic [127:0] keep_bytes(input logic [127:0] b, input int n);
        logic [127:0] r = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < n) r[127-8*i -: 8] = b[127-8*i -: 8];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model state
    logic [127:0] exp_ctr = '0;
    bit           exp_y0 = 1'b0;
    logic [127:0] exp_ek0 = '0;
    logic [127:0] din_q[$];
    int           nb_q[$];
    logic [127:0] out_q[$];
    int           onb_q[$];
    int           rsp_timer = 0;
    int           rsp_delay = 1;
    int           ready_mode = 0;
    int           cyc = 0;
    logic [127:0] rsp_hold = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            ciph_rsp_valid = 1'b0;
            if (rsp_timer > 0) begin
                rsp_timer--;
                if (rsp_timer == 0) begin
                    ciph_rsp_valid = 1'b1;
                    ciph_rsp_block = rsp_hold;
                end
            end
            ciph_req_ready = (ready_mode == 0) ? 1'b1 : (cyc % 3 == 0);
            if (iv_valid && iv_ready) begin
                exp_ctr = {iv_data, 31'b0, 1'b1};
                exp_y0 = 1'b1;
            end else if (din_valid && din_ready) begin
                din_q.push_back(din_block);
                nb_q.push_back(norm_nb(din_nbytes));
            end
            if (ciph_req_valid && ciph_req_ready) begin
                check(ciph_req_block == exp_ctr, exp_y0 ? "R1 first counter block" : "R2 next counter block",
                      ciph_req_block, exp_ctr);
                rsp_hold = ks_of(ciph_req_block);
                rsp_timer = rsp_delay;
                if (exp_y0) begin
                    exp_ek0 = ks_of(exp_ctr);
                end else if (din_q.size() > 0) begin
                    logic [127:0] d;
                    int n;
                    d = din_q.pop_front();
                    n = nb_q.pop_front();
                    out_q.push_back(keep_bytes(d ^ ks_of(exp_ctr), n));
                    onb_q.push_back(n);
                end
                exp_y0 = 1'b0;
                exp_ctr[31:0] = exp_ctr[31:0] + 32'd1;
            end
            if (dout_valid) begin
                if (out_q.size() == 0) begin
                    check(1'b0, "R4 unexpected output pulse", dout_block, '0);
                end else begin
                    logic [127:0] e;
                    int en;
                    e = out_q.pop_front();
                    en = onb_q.pop_front();
                    check(dout_block == e, "R4/R5 output block", dout_block, e);
                    check(int'(dout_nbytes) == en, "R5 output count", 128'(dout_nbytes), 128'(en));
                end
            end
        end
    end

    // narrow instance responder and recorder
    logic [127:0] n_reqs[$];
    bit           n_pend = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            n_rsp_valid = n_pend;
            n_pend = 1'b0;
            if (n_req_valid) begin
                n_pend = 1'b1;
                if (n_reqs.size() < 12) n_reqs.push_back(n_req_block);
            end
        end
    end

    task automatic send_iv(input logic [95:0] v);
        bit acc;
        iv_data = v;
        iv_valid = 1'b1;
        forever begin
            @(negedge clk);
            acc = iv_ready;
            @(posedge clk);
            #1;
            if (acc) break;
        end
        iv_valid = 1'b0;
    endtask

    task automatic send_blk(input logic [127:0] b, input logic [4:0] n);
        bit acc;
        din_block = b;
        din_nbytes = n;
        din_valid = 1'b1;
        forever begin
            @(negedge clk);
            acc = din_ready;
            @(posedge clk);
            #1;
            if (acc) break;
        end
        din_valid = 1'b0;
    endtask

    task automatic drain();
        while (din_q.size() != 0 || out_q.size() != 0 || rsp_timer != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        logic [95:0] iv_a;
        logic [95:0] iv_b;
        logic [127:0] old_ek0;
        iv_a = 96'h0123_4567_89AB_CDEF_F00D_CAFE;
        iv_b = 96'hFEDC_BA98_7654_3210_1357_9BDF;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(iv_ready == 1'b1, "R8 iv_ready after reset", 128'(iv_ready), 128'd1);
        check({din_ready, ciph_req_valid, dout_valid, ek0_valid} == 4'b0, "R8 outputs low after reset",
              128'({din_ready, ciph_req_valid, dout_valid, ek0_valid}), 128'd0);
        check(din_ready == 1'b0, "R7 no data accepted before IV", 128'(din_ready), 128'd0);

        // full blocks, no stalls
        @(posedge clk); #1;
        send_iv(iv_a);
        for (int k = 0; k < 4; k++) send_blk({32'hA5A5_0000 + k, 96'h1111_2222_3333_4444_5555_6666}, 5'd16);
        drain();
        check(ek0_valid && ek0_block == exp_ek0, "R6 stored initial keystream", ek0_block, exp_ek0);

        // partial blocks with stalls and slow responses
        ready_mode = 1;
        rsp_delay = 3;
        send_blk(128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100, 5'd1);
        send_blk(128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, 5'd7);
        send_blk(128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF, 5'd15);
        send_blk(128'h1234_5678_9ABC_DEF0_1234_5678_9ABC_DEF0, 5'd16);
        send_blk(128'hCAFE_F00D_CAFE_F00D_CAFE_F00D_CAFE_F00D, 5'd0);
        send_blk(128'h8080_8080_8080_8080_8080_8080_8080_8080, 5'd20);
        drain();

        // R1: IV offered while a request is in flight is ignored
        old_ek0 = ek0_block;
        send_blk(128'h7777_6666_5555_4444_3333_2222_1111_0000, 5'd9);
        iv_data = iv_b;
        iv_valid = 1'b1;
        @(posedge clk); #1;
        iv_valid = 1'b0;
        drain();
        check(ek0_valid && ek0_block == old_ek0, "R1 IV ignored while busy keeps stored block", ek0_block, old_ek0);
        send_blk(128'h0F0F_0F0F_F0F0_F0F0_0F0F_0F0F_F0F0_F0F0, 5'd16);
        drain();

        // R6: reload clears and replaces the stored block
        ready_mode = 0;
        rsp_delay = 2;
        send_iv(iv_b);
        check(ek0_valid == 1'b0, "R6 reload clears ek0_valid", 128'(ek0_valid), 128'd0);
        send_blk(128'h4242_4242_4242_4242_4242_4242_4242_4242, 5'd3);
        drain();
        check(ek0_valid && ek0_block == exp_ek0, "R6 new stored initial keystream", ek0_block, exp_ek0);

        // R3: wrap on the narrow instance
        n_iv_valid = 1'b1;
        @(posedge clk); #1;
        n_iv_valid = 1'b0;
        n_din_valid = 1'b1;
        while (n_reqs.size() < 10) @(negedge clk);
        n_din_valid = 1'b0;
        check(n_reqs[0] == {n_iv_data, 3'b001}, "R1 narrow first block", n_reqs[0], {n_iv_data, 3'b001});
        check(n_reqs[6] == {n_iv_data, 3'b111}, "R3 field at all ones", n_reqs[6], {n_iv_data, 3'b111});
        check(n_reqs[7] == {n_iv_data, 3'b000}, "R3 wrap to zero keeps upper bits", n_reqs[7], {n_iv_data, 3'b000});
        check(n_reqs[8] == {n_iv_data, 3'b001}, "R3 count continues after wrap", n_reqs[8], {n_iv_data, 3'b001});
        repeat (5) @(negedge clk);
        finish_up();
    end

endmodule